// File: doc/BRIEF.md
# NAND Two-Plane Block Erase Sequencer

This block runs a two-plane block erase on a NAND flash bus. A single `start` pulse hands it two block addresses, one for plane 0 and one for plane 1. It also takes a bus-width select and a sequence-mode select. The block first checks the plane bits of both addresses.

If the check passes, it issues these steps on the bus:

- the setup command and three row bytes for the first block;
- a wait for the device to become ready;
- the same setup and row bytes for the second block;
- the erase confirm;
- a second ready wait;
- a status read.

In the alternate mode, an intermediate confirm byte follows the first block's row bytes. When the status reports a failure, the block queries each plane in turn with the per-plane status command. This identifies which plane failed.

Every bus cycle has a fixed length, counted in clock cycles. The ready/busy pin is synchronised before use. Each ready wait is limited by a timeout that software programs. The results are held until the next start that the block accepts. There is no data stream on this block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `nand_mpe_erase_seq`

## Requirements
- R1: A `start` in idle whose first address has a plane bit of 1, or whose second address has a plane bit of 0, is rejected. No bus cycle takes place. `done` and `addr_err` are 1 from the next clock, and `fail`, `plane0_fail`, `plane1_fail` and `timed_out` are 0.
- R2: With `wide_bus`=0 (x8), the plane bit is address bit 18 and the row is bits 35:12. With `wide_bus`=1 (x16), the plane bit is bit 17 and the row is bits 34:11. The row goes out as three address bytes, least significant byte first.
- R3: With `onfi_mode`=0, the bus order is: command 60h, row bytes of block A, ready wait, command 60h, row bytes of block B, command D0h, ready wait, command 70h, one read.
- R4: With `onfi_mode`=1, command D1h is inserted after block A's third row byte and before the first ready wait. Everything else follows R3.
- R5: Each write cycle holds `nf_we_n` low for HALF_CYC clocks and then high for HALF_CYC clocks, with the byte on `nf_io_out` and `nf_io_oe`=1. `nf_cle` is 1 for command bytes and `nf_ale` is 1 for address bytes, and they are never 1 together. Each read cycle holds `nf_re_n` low for HALF_CYC clocks with `nf_io_oe`=0. `nf_we_n` and `nf_re_n` are never low together.
- R6: A ready wait first lets WB_CYC clocks pass. It then waits for the synchronised `nf_rb` to be 1. No write cycle starts while `nf_rb` is 0.
- R7: If `nf_rb` stays 0 for more than `busy_limit` polling clocks, the sequence stops. `done` and `timed_out` become 1, `fail` stays 0, and no further bus cycle is issued.
- R8: When bit 0 of the 70h status byte is 1, `fail` is set. The block then issues command 78h with block A's three row bytes and one read, followed by 78h with block B's three row bytes and one read. `plane0_fail` and `plane1_fail` take bit 0 of the first and second of these bytes.
- R9: When bit 0 of the 70h status byte is 0, `done` is set with `fail`, `plane0_fail` and `plane1_fail` all 0, and no 78h command is issued.
- R10: `done` and the result flags hold their values until a start is accepted. While `active` is 1, `start` is ignored.
- R11: After reset, `nf_we_n`=`nf_re_n`=1, `nf_cle`=`nf_ale`=`nf_io_oe`=0, and `active`=`done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to erase |
| blk_addr_a | input | ADDR_W | Full flash address of the plane-0 block |
| blk_addr_b | input | ADDR_W | Full flash address of the plane-1 block |
| wide_bus | input | 1 | 0 = x8 device, 1 = x16 device |
| onfi_mode | input | 1 | 1 = insert the intermediate D1h confirm |
| busy_limit | input | TMO_W | Polling clocks allowed per ready wait |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_io_out | output | 8 | Byte driven onto the I/O bus |
| nf_io_oe | output | 1 | I/O output enable |
| nf_io_in | input | 8 | Byte read from the I/O bus |
| nf_rb | input | 1 | Ready (1) / busy (0), asynchronous |
| active | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, results valid |
| fail | output | 1 | Combined erase status reported a failure |
| plane0_fail | output | 1 | Plane 0 reported a failure |
| plane1_fail | output | 1 | Plane 1 reported a failure |
| timed_out | output | 1 | A ready wait ran out |
| addr_err | output | 1 | Start rejected due to plane bits |

## Verification
The bench puts addresses valid for x16 on an x8 run. A design that picks the plane bit from the wrong position would accept these and erase the wrong blocks. Separate runs report the failure on plane 0 alone and on plane 1 alone. A design that swaps the per-plane queries or skips the second one would show up with the wrong plane flag. One run holds busy past the limit. A design with a broken timeout would hang, or would go on to issue the status command. A start pulse arrives in the middle of a run. A design that accepts it would restart the bus order, or would flag an address error.

// File: rtl/nand_mpe_pkg.sv
package nand_mpe_pkg;

  localparam int ROW_BYTES = 3;
  localparam int ROW_W     = 8 * ROW_BYTES;
  localparam int STEP_W    = 5;

  localparam logic [7:0] CMD_SETUP    = 8'h60;
  localparam logic [7:0] CMD_INTERIM  = 8'hD1;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_PL_STAT  = 8'h78;

  localparam logic [STEP_W-1:0] STEP_PLANE_QUERY = 5'd14;
  localparam logic [STEP_W-1:0] STEP_FINISH      = 5'd24;

  typedef enum logic [2:0] {
    OP_CMD, OP_ADDR, OP_BUSY, OP_RD_ST, OP_RD_P0, OP_RD_P1, OP_SKIP, OP_END
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [7:0] data;
  } op_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_HOLD} sq_state_e;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_state_e;
  typedef enum logic [1:0] {BW_IDLE, BW_SETTLE, BW_POLL} bw_state_e;

endpackage

// File: rtl/nand_mpe_plane_chk.sv
module nand_mpe_plane_chk
  import nand_mpe_pkg::*;
#(
  parameter int ADDR_W        = 36,
  parameter int COL_BITS_X8   = 12,
  parameter int COL_BITS_X16  = 11,
  parameter int PLANE_BIT_X8  = 18,
  parameter int PLANE_BIT_X16 = 17
) (
  input  logic [ADDR_W-1:0] blk_addr_a,
  input  logic [ADDR_W-1:0] blk_addr_b,
  input  logic              wide_bus,
  output logic              plane_ok,
  output logic [ROW_W-1:0]  row_a,
  output logic [ROW_W-1:0]  row_b
);

  logic pa, pb;
  logic unused_addr_bits;

  always_comb begin
    if (wide_bus) begin
      pa    = blk_addr_a[PLANE_BIT_X16];
      pb    = blk_addr_b[PLANE_BIT_X16];
      row_a = blk_addr_a[COL_BITS_X16 +: ROW_W];
      row_b = blk_addr_b[COL_BITS_X16 +: ROW_W];
    end else begin
      pa    = blk_addr_a[PLANE_BIT_X8];
      pb    = blk_addr_b[PLANE_BIT_X8];
      row_a = blk_addr_a[COL_BITS_X8 +: ROW_W];
      row_b = blk_addr_b[COL_BITS_X8 +: ROW_W];
    end
  end

  // first block must sit in plane 0, second in plane 1
  assign plane_ok = !pa && pb;

  // column bits carry no meaning for an erase
  assign unused_addr_bits = ^{blk_addr_a, blk_addr_b};

endmodule

// File: rtl/nand_mpe_step_rom.sv
module nand_mpe_step_rom
  import nand_mpe_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              onfi,
  input  logic [ROW_W-1:0]  row_a,
  input  logic [ROW_W-1:0]  row_b,
  output op_t               op
);

  function automatic logic [7:0] row_byte(input logic [ROW_W-1:0] r, input int idx);
    return r[8*idx +: 8];
  endfunction

  always_comb begin
    op = '{kind: OP_END, data: 8'h00};
    case (step)
      5'd0:  op = '{kind: OP_CMD,  data: CMD_SETUP};
      5'd1:  op = '{kind: OP_ADDR, data: row_byte(row_a, 0)};
      5'd2:  op = '{kind: OP_ADDR, data: row_byte(row_a, 1)};
      5'd3:  op = '{kind: OP_ADDR, data: row_byte(row_a, 2)};
      5'd4:  op = onfi ? '{kind: OP_CMD, data: CMD_INTERIM}
                       : '{kind: OP_SKIP, data: 8'h00};
      5'd5:  op = '{kind: OP_BUSY, data: 8'h00};
      5'd6:  op = '{kind: OP_CMD,  data: CMD_SETUP};
      5'd7:  op = '{kind: OP_ADDR, data: row_byte(row_b, 0)};
      5'd8:  op = '{kind: OP_ADDR, data: row_byte(row_b, 1)};
      5'd9:  op = '{kind: OP_ADDR, data: row_byte(row_b, 2)};
      5'd10: op = '{kind: OP_CMD,  data: CMD_CONFIRM};
      5'd11: op = '{kind: OP_BUSY, data: 8'h00};
      5'd12: op = '{kind: OP_CMD,  data: CMD_STATUS};
      5'd13: op = '{kind: OP_RD_ST, data: 8'h00};
      5'd14: op = '{kind: OP_CMD,  data: CMD_PL_STAT};
      5'd15: op = '{kind: OP_ADDR, data: row_byte(row_a, 0)};
      5'd16: op = '{kind: OP_ADDR, data: row_byte(row_a, 1)};
      5'd17: op = '{kind: OP_ADDR, data: row_byte(row_a, 2)};
      5'd18: op = '{kind: OP_RD_P0, data: 8'h00};
      5'd19: op = '{kind: OP_CMD,  data: CMD_PL_STAT};
      5'd20: op = '{kind: OP_ADDR, data: row_byte(row_b, 0)};
      5'd21: op = '{kind: OP_ADDR, data: row_byte(row_b, 1)};
      5'd22: op = '{kind: OP_ADDR, data: row_byte(row_b, 2)};
      5'd23: op = '{kind: OP_RD_P1, data: 8'h00};
      default: op = '{kind: OP_END, data: 8'h00};
    endcase
  end

endmodule

// File: rtl/nand_mpe_bus_phy.sv
module nand_mpe_bus_phy
  import nand_mpe_pkg::*;
#(
  parameter int HALF_CYC = 3,
  parameter int FAIL_BIT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       is_read,
  input  logic       is_cmd,
  input  logic [7:0] wdata,
  input  logic [7:0] io_in,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       done,
  output logic       rd_flag
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  ph_state_e    st;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic          unused_io_bits;

  assign unused_io_bits = ^io_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      rd_q    <= 1'b0;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      io_out  <= 8'h00;
      io_oe   <= 1'b0;
      done    <= 1'b0;
      rd_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        PH_IDLE: if (go) begin
          st   <= PH_LOW;
          cnt  <= '0;
          rd_q <= is_read;
          if (is_read) begin
            re_n <= 1'b0;
          end else begin
            we_n   <= 1'b0;
            cle    <= is_cmd;
            ale    <= !is_cmd;
            io_out <= wdata;
            io_oe  <= 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt == LAST) begin
            st   <= PH_HIGH;
            cnt  <= '0;
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (rd_q) rd_flag <= io_in[FAIL_BIT];
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == LAST) begin
            st    <= PH_IDLE;
            done  <= 1'b1;
            cle   <= 1'b0;
            ale   <= 1'b0;
            io_oe <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_mpe_busy_wait.sv
module nand_mpe_busy_wait
  import nand_mpe_pkg::*;
#(
  parameter int WB_CYC = 4,
  parameter int TMO_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             rb_async,
  input  logic [TMO_W-1:0] limit,
  output logic             done,
  output logic             expired
);

  localparam logic [TMO_W-1:0] SETTLE_LAST = TMO_W'(WB_CYC - 1);

  bw_state_e        st;
  logic [TMO_W-1:0] cnt;
  logic             rb_m, rb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_m <= 1'b1;
      rb_s <= 1'b1;
    end else begin
      rb_m <= rb_async;
      rb_s <= rb_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BW_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      expired <= 1'b0;
    end else begin
      done    <= 1'b0;
      expired <= 1'b0;
      case (st)
        BW_IDLE: if (go) begin
          st  <= BW_SETTLE;
          cnt <= '0;
        end
        BW_SETTLE: begin
          if (cnt >= SETTLE_LAST) begin
            st  <= BW_POLL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BW_POLL: begin
          if (rb_s) begin
            st   <= BW_IDLE;
            done <= 1'b1;
          end else if (cnt >= limit) begin
            st      <= BW_IDLE;
            expired <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= BW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_mpe_erase_seq.sv
module nand_mpe_erase_seq
  import nand_mpe_pkg::*;
#(
  parameter int ADDR_W        = 36,
  parameter int COL_BITS_X8   = 12,
  parameter int COL_BITS_X16  = 11,
  parameter int PLANE_BIT_X8  = 18,
  parameter int PLANE_BIT_X16 = 17,
  parameter int HALF_CYC      = 3,
  parameter int WB_CYC        = 4,
  parameter int TMO_W         = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] blk_addr_a,
  input  logic [ADDR_W-1:0] blk_addr_b,
  input  logic              wide_bus,
  input  logic              onfi_mode,
  input  logic [TMO_W-1:0]  busy_limit,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [7:0]        nf_io_out,
  output logic              nf_io_oe,
  input  logic [7:0]        nf_io_in,
  input  logic              nf_rb,
  output logic              active,
  output logic              done,
  output logic              fail,
  output logic              plane0_fail,
  output logic              plane1_fail,
  output logic              timed_out,
  output logic              addr_err
);

  sq_state_e         state;
  logic [STEP_W-1:0] step;
  logic [ROW_W-1:0]  row_a, row_b, row_a_q, row_b_q;
  logic              plane_ok, onfi_q;
  logic              phy_go, phy_done, phy_flag;
  logic              bw_go, bw_done, bw_exp;
  logic [TMO_W-1:0]  limit_q;
  op_t               op;
  logic              op_is_read;

  nand_mpe_plane_chk #(
    .ADDR_W(ADDR_W), .COL_BITS_X8(COL_BITS_X8), .COL_BITS_X16(COL_BITS_X16),
    .PLANE_BIT_X8(PLANE_BIT_X8), .PLANE_BIT_X16(PLANE_BIT_X16)
  ) u_plane (
    .blk_addr_a(blk_addr_a), .blk_addr_b(blk_addr_b), .wide_bus(wide_bus),
    .plane_ok(plane_ok), .row_a(row_a), .row_b(row_b)
  );

  nand_mpe_step_rom u_rom (
    .step(step), .onfi(onfi_q), .row_a(row_a_q), .row_b(row_b_q), .op(op)
  );

  assign op_is_read = (op.kind == OP_RD_ST) || (op.kind == OP_RD_P0) ||
                      (op.kind == OP_RD_P1);

  nand_mpe_bus_phy #(.HALF_CYC(HALF_CYC), .FAIL_BIT(0)) u_phy (
    .clk(clk), .rst_n(rst_n), .go(phy_go), .is_read(op_is_read),
    .is_cmd(op.kind == OP_CMD), .wdata(op.data), .io_in(nf_io_in),
    .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
    .io_out(nf_io_out), .io_oe(nf_io_oe), .done(phy_done), .rd_flag(phy_flag)
  );

  nand_mpe_busy_wait #(.WB_CYC(WB_CYC), .TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .go(bw_go), .rb_async(nf_rb),
    .limit(limit_q), .done(bw_done), .expired(bw_exp)
  );

  assign active = (state != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      step        <= '0;
      row_a_q     <= '0;
      row_b_q     <= '0;
      onfi_q      <= 1'b0;
      limit_q     <= '0;
      phy_go      <= 1'b0;
      bw_go       <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      plane0_fail <= 1'b0;
      plane1_fail <= 1'b0;
      timed_out   <= 1'b0;
      addr_err    <= 1'b0;
    end else begin
      phy_go <= 1'b0;
      bw_go  <= 1'b0;
      case (state)
        SQ_IDLE: if (start) begin
          fail        <= 1'b0;
          plane0_fail <= 1'b0;
          plane1_fail <= 1'b0;
          timed_out   <= 1'b0;
          if (!plane_ok) begin
            done     <= 1'b1;
            addr_err <= 1'b1;
          end else begin
            done     <= 1'b0;
            addr_err <= 1'b0;
            row_a_q  <= row_a;
            row_b_q  <= row_b;
            onfi_q   <= onfi_mode;
            limit_q  <= busy_limit;
            step     <= '0;
            state    <= SQ_LAUNCH;
          end
        end
        SQ_LAUNCH: begin
          case (op.kind)
            OP_SKIP: step <= step + 1'b1;
            OP_END: begin
              state <= SQ_IDLE;
              done  <= 1'b1;
            end
            OP_BUSY: begin
              bw_go <= 1'b1;
              state <= SQ_HOLD;
            end
            default: begin
              phy_go <= 1'b1;
              state  <= SQ_HOLD;
            end
          endcase
        end
        SQ_HOLD: begin
          if (bw_exp) begin
            timed_out <= 1'b1;
            done      <= 1'b1;
            state     <= SQ_IDLE;
          end else if (bw_done || phy_done) begin
            state <= SQ_LAUNCH;
            step  <= step + 1'b1;
            case (op.kind)
              OP_RD_ST: begin
                fail <= phy_flag;
                step <= phy_flag ? STEP_PLANE_QUERY : STEP_FINISH;
              end
              OP_RD_P0: plane0_fail <= phy_flag;
              OP_RD_P1: plane1_fail <= phy_flag;
              default: ;
            endcase
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_mpe_erase_chk.sv
module nand_mpe_erase_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic nf_cle,
  input logic nf_ale,
  input logic nf_we_n,
  input logic nf_re_n,
  input logic nf_io_oe,
  input logic active,
  input logic done,
  input logic fail,
  input logic plane0_fail,
  input logic plane1_fail,
  input logic timed_out,
  input logic addr_err
);

  a_r5_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_io_oe);

  a_r1_reject_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!active && nf_we_n && nf_re_n && !nf_cle && !nf_ale));

  a_r10_results_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done &&
      $stable({fail, plane0_fail, plane1_fail, timed_out, addr_err})));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);

  a_r7_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> (done && !fail));

  a_r8_plane_implies_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (plane0_fail || plane1_fail) |-> fail);

  a_r10_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start));

endmodule

bind nand_mpe_erase_seq nand_mpe_erase_chk u_erase_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_oe(nf_io_oe), .active(active),
  .done(done), .fail(fail), .plane0_fail(plane0_fail), .plane1_fail(plane1_fail),
  .timed_out(timed_out), .addr_err(addr_err)
);

// File: tb/nand_mpe_erase_seq_tb_top.sv
module nand_mpe_erase_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int AW = 36;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic wide = 0, onfi = 0;
  logic [19:0] limit = 20'd1000;
  logic cle, ale, we_n, re_n, io_oe, nf_rb;
  logic [7:0] io_out, io_in;
  logic active, done, fail, p0f, p1f, tmo, aerr;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int got_q[$], exp_q[$];
  bit cfg_sr0, cfg_p0, cfg_p1;
  int cfg_short = 20, cfg_erase = 150;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_mpe_erase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr_a(addr_a), .blk_addr_b(addr_b),
    .wide_bus(wide), .onfi_mode(onfi), .busy_limit(limit), .nf_cle(cle), .nf_ale(ale),
    .nf_we_n(we_n), .nf_re_n(re_n), .nf_io_out(io_out), .nf_io_oe(io_oe),
    .nf_io_in(io_in), .nf_rb(nf_rb), .active(active), .done(done), .fail(fail),
    .plane0_fail(p0f), .plane1_fail(p1f), .timed_out(tmo), .addr_err(aerr)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  // device model and bus monitor, sampled away from the active edge
  logic prev_we = 1, prev_re = 1;
  int we_len = 0, re_len = 0, rb_cnt = 0, addr_idx = 0;
  logic [7:0] last_cmd = 8'h00;
  bit plane_sel = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      nf_rb <= 1'b1;
      io_in <= 8'h00;
      rb_cnt = 0;
      prev_we = 1;
      prev_re = 1;
    end else begin
      if (rb_cnt > 0) begin
        rb_cnt--;
        if (rb_cnt == 0) nf_rb <= 1'b1;
      end
      if (!we_n) begin
        we_len++;
        if (!(cle ^ ale) || !io_oe) chk("R5 latch/oe during write", {cle, ale, io_oe}, 0);
        if (prev_we && !nf_rb) chk("R6 write while busy", 1, 0);
      end
      if (!re_n) begin
        re_len++;
        if (prev_re) begin
          got_q.push_back('h300);
          if (last_cmd == 8'h70) io_in <= {7'b1100000, cfg_sr0};
          else io_in <= {7'b1100000, plane_sel ? cfg_p1 : cfg_p0};
        end
        if (io_oe) chk("R5 io driven on read", io_oe, 0);
      end
      if (we_n && !prev_we) begin
        chk("R5 write low length", we_len, HALF);
        we_len = 0;
        if (cle) begin
          got_q.push_back('h100 | io_out);
          last_cmd = io_out;
          addr_idx = 0;
          if (io_out == 8'hD1) begin rb_cnt = cfg_short; nf_rb <= 1'b0; end
          if (io_out == 8'hD0) begin rb_cnt = cfg_erase; nf_rb <= 1'b0; end
        end else begin
          got_q.push_back('h200 | io_out);
          if (last_cmd == 8'h78 && addr_idx == 0) plane_sel = io_out[6];
          addr_idx++;
        end
      end
      if (re_n && !prev_re) begin
        chk("R5 read low length", re_len, HALF);
        re_len = 0;
      end
      prev_we = we_n;
      prev_re = re_n;
    end
  end

  function automatic logic [AW-1:0] mk(input logic [23:0] row, input bit w);
    return w ? ({12'b0, row} << 11) : ({12'b0, row} << 12);
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run_erase(input logic [23:0] ra, input logic [23:0] rbk, input bit w,
                           input bit o, input bit sr0, input bit pf0, input bit pf1,
                           input int lim, input int er, input bit exp_to, input bit poke,
                           input string tag);
    logic [AW-1:0] keep_b;
    exp_q = {};
    got_q = {};
    exp_q.push_back('h160);
    for (int i = 0; i < 3; i++) exp_q.push_back('h200 | ra[8*i +: 8]);
    if (o) exp_q.push_back('h1D1);
    exp_q.push_back('h160);
    for (int i = 0; i < 3; i++) exp_q.push_back('h200 | rbk[8*i +: 8]);
    exp_q.push_back('h1D0);
    if (!exp_to) begin
      exp_q.push_back('h170);
      exp_q.push_back('h300);
      if (sr0) begin
        exp_q.push_back('h178);
        for (int i = 0; i < 3; i++) exp_q.push_back('h200 | ra[8*i +: 8]);
        exp_q.push_back('h300);
        exp_q.push_back('h178);
        for (int i = 0; i < 3; i++) exp_q.push_back('h200 | rbk[8*i +: 8]);
        exp_q.push_back('h300);
      end
    end
    cfg_sr0 = sr0; cfg_p0 = pf0; cfg_p1 = pf1; cfg_erase = er;
    addr_a = mk(ra, w); addr_b = mk(rbk, w); wide = w; onfi = o; limit = 20'(lim);
    pulse_start();
    if (poke) begin
      repeat (30) @(negedge clk);
      keep_b = addr_b;
      addr_b = '0;
      pulse_start();
      addr_b = keep_b;
    end
    for (int k = 0; k < 20000 && !done; k++) @(negedge clk);
    @(negedge clk);
    chk({tag, " done"}, done, 1);
    chk({tag, " bus order"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] != exp_q[i]) begin
        chk({tag, " bus item"}, got_q[i], exp_q[i]);
        break;
      end
    chk({tag, " fail R8 R9"}, fail, sr0 && !exp_to);
    chk({tag, " plane0 R8"}, p0f, sr0 && pf0 && !exp_to);
    chk({tag, " plane1 R8"}, p1f, sr0 && pf1 && !exp_to);
    chk({tag, " timeout R7"}, tmo, exp_to);
    chk({tag, " addr_err R10"}, aerr, 0);
  endtask

  task automatic run_reject(input logic [AW-1:0] a, input logic [AW-1:0] b, input bit w,
                            input string tag);
    got_q = {};
    addr_a = a; addr_b = b; wide = w;
    pulse_start();
    repeat (20) @(negedge clk);
    chk({tag, " done"}, done, 1);
    chk({tag, " addr_err"}, aerr, 1);
    chk({tag, " no bus"}, got_q.size(), 0);
    chk({tag, " flags clear"}, {fail, p0f, p1f, tmo}, 0);
  endtask

  initial begin
    logic [4:0] snap;
    repeat (3) @(negedge clk);
    chk("R11 strobes idle", {we_n, re_n, cle, ale, io_oe}, 5'b11000);
    chk("R11 status idle", {active, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_erase(24'h032180, 24'h0321C0, 0, 0, 0, 0, 0, 1000, 150, 0, 0, "R3 R9 x8 trad");
    run_erase(24'h1A5500, 24'h1A5540, 0, 1, 0, 0, 0, 1000, 150, 0, 0, "R4 x8 onfi");
    run_erase(24'h000B80, 24'h000BC0, 0, 0, 1, 1, 0, 1000, 150, 0, 0, "R8 plane0");
    run_erase(24'h3F0200, 24'h3F0240, 1, 1, 1, 0, 1, 1000, 150, 0, 0, "R2 R8 x16 plane1");
    snap = {fail, p0f, p1f, tmo, aerr};
    repeat (12) @(negedge clk);
    chk("R10 results held", {done, fail, p0f, p1f, tmo, aerr}, {1'b1, snap});

    run_reject(mk(24'h000040, 0), mk(24'h000040, 0), 0, "R1 plane A set");
    run_reject(mk(24'h000080, 1), mk(24'h0000C0, 1), 0, "R1 R2 x16 addr on x8");

    run_erase(24'h044400, 24'h044440, 0, 0, 1, 1, 1, 1000, 150, 0, 1, "R10 start ignored");
    run_erase(24'h012300, 24'h012340, 0, 1, 0, 0, 0, 40, 400, 1, 0, "R7 timeout");
    repeat (600) @(negedge clk);
    chk("R7 no bus after timeout", got_q.size(), exp_q.size());
    run_erase(24'h200000, 24'h200040, 1, 0, 0, 0, 0, 1000, 150, 0, 0, "R6 R2 x16 trad");

    finish_run();
  end

endmodule